// File: doc/BRIEF.md
# Fully-Associative Word Cache with True LRU Replacement

This block is a small fully-associative cache of eight entries, each holding one 32-bit word, placed in front of a 32-word memory that is addressed in bytes. The 7-bit request address has no index field. Its upper five bits are the word number, and the whole word number serves as the tag. Each lookup compares that tag against every stored tag in the same cycle. An 8-to-1 select then returns the word of the single matching entry.

On a read miss, the word arrives from memory through a combinational read port. It is stored in the lowest-numbered empty entry. When no entry is empty, it replaces the least recently used entry. A full recency order over all eight entries is kept at all times. Writes go through to memory in every case. A write hit also updates the cached copy. A write miss allocates nothing.

A request is accepted in one cycle. Its response appears on the registered outputs in the next cycle. The response reports hit or miss, the entry used and the data word.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` is 0, and the first read of any word misses.
- R2: The tag is `req_addr[6:2]`. The byte offset `req_addr[1:0]` has no effect on hit, entry or data.
- R3: A read whose tag matches a valid entry returns `rsp_hit`=1, that entry's number on `rsp_way` and its stored word on `rsp_data`, in the cycle after the request.
- R4: A read miss returns `rsp_hit`=0 and the word present on `mem_rdata` during the request cycle. That word and its tag are stored in the entry reported on `rsp_way`.
- R5: While empty entries exist, read misses fill them in ascending entry order, starting at 0.
- R6: When all eight entries are valid, a read miss replaces the least recently used entry.
- R7: Read hits, write hits and fills each make the entry used the most recently used one.
- R8: At most one entry matches any tag.
- R9: Every write drives `mem_we`=1, `mem_addr`=`req_addr[6:2]` and `mem_wdata`=`req_wdata` in the request cycle. A write hit replaces the cached word and reports `rsp_hit`=1. A write miss reports `rsp_hit`=0, leaves every entry and the recency order unchanged, and returns `req_wdata` on `rsp_data`.
- R10: Starting empty, read accesses to word addresses 0, 8, 0, 6, 8, 16 give miss, miss, hit, miss, hit, miss.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address; bits 6..2 are the word tag |
| req_wdata | input | 32 | Write data |
| mem_we | output | 1 | Memory write strobe (write-through) |
| mem_addr | output | 5 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational from `mem_addr` |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Request hit in the cache |
| rsp_way | output | 3 | Entry used (meaningless on a write miss) |
| rsp_data | output | 32 | Read word, or the written word for writes |

## Verification
A corrupted recency rank does not show at the ports until the cache is full and a later miss evicts the wrong entry. The response then reports an unexpected `rsp_way`, and a later read of the wrongly evicted word misses when it should hit. A wrong tag or valid bit shows on the next access to that word, through `rsp_hit` or `rsp_data`. The bench runs a behavioural model that holds a recency queue, and compares every response cycle against it. It runs long fill-and-evict sequences so that rank errors surface within a few accesses after the cache fills.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
    localparam int unsigned CA_WAYS   = 8;
    localparam int unsigned CA_TAG_W  = 5;
    localparam int unsigned CA_OFFS_W = 2;
    localparam int unsigned CA_DATA_W = 32;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter  int unsigned WAYS   = 8,
    parameter  int unsigned TAG_W  = 5,
    parameter  int unsigned DATA_W = 32,
    localparam int unsigned WAY_W  = $clog2(WAYS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WAYS-1:0]                   valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]        tags_i,
    input  logic [WAYS-1:0][DATA_W-1:0]       data_i,
    input  logic [TAG_W-1:0]                  tag_i,
    output logic [WAYS-1:0]                   match_o,
    output logic                              hit_o,
    output logic [WAY_W-1:0]                  way_o,
    output logic [DATA_W-1:0]                 data_o
);
    // parallel compare, one comparator per entry
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    assign hit_o = |match_o;

    // AND-OR select: valid because at most one entry matches
    always_comb begin
        way_o  = '0;
        data_o = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match_o[i]) begin
                way_o  = way_o | WAY_W'(i);
                data_o = data_o | data_i[i];
            end
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o)); // R8
endmodule

// File: rtl/fa_lru_order.sv
module fa_lru_order #(
    parameter  int unsigned WAYS  = 8,
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   valid_i,
    input  logic              touch_i,
    input  logic [WAY_W-1:0]  touch_way_i,
    output logic [WAY_W-1:0]  victim_o
);
    // rank 0 = most recent, WAYS-1 = least recent; ranks form a permutation
    typedef struct packed {
        logic [WAYS-1:0][WAY_W-1:0] rank;
    } lru_t;

    lru_t lru_d, lru_q;
    logic [WAYS-1:0] oldest;
    logic            free_found;

    always_comb begin
        lru_d = lru_q;
        if (touch_i) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == touch_way_i) begin
                    lru_d.rank[i] = '0;
                end else if (lru_q.rank[i] < lru_q.rank[touch_way_i]) begin
                    lru_d.rank[i] = lru_q.rank[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            oldest[i] = (lru_q.rank[i] == WAY_W'(WAYS - 1));
        end
        victim_o   = '0;
        free_found = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!free_found && !valid_i[i]) begin
                victim_o   = WAY_W'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < WAYS; i++) begin
                if (oldest[i]) victim_o = WAY_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) lru_q.rank[i] <= WAY_W'(i);
        end else begin
            lru_q <= lru_d;
        end
    end

    AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1); // R6
    AST_MRU_AFTER_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> lru_q.rank[$past(touch_way_i)] == '0); // R7
endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
    import fa_cache_pkg::*;
#(
    parameter  int unsigned WAYS   = CA_WAYS,
    parameter  int unsigned TAG_W  = CA_TAG_W,
    parameter  int unsigned OFFS_W = CA_OFFS_W,
    parameter  int unsigned DATA_W = CA_DATA_W,
    localparam int unsigned ADDR_W = TAG_W + OFFS_W,
    localparam int unsigned WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_we,
    output logic [TAG_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic [WAYS-1:0]              valid;
        logic [WAYS-1:0][TAG_W-1:0]   tag;
        logic [WAYS-1:0][DATA_W-1:0]  data;
        logic                         rsp_valid;
        logic                         rsp_hit;
        logic [WAY_W-1:0]             rsp_way;
        logic [DATA_W-1:0]            rsp_data;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]  lookup_tag;
    logic [WAYS-1:0]   match_vec;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [DATA_W-1:0] hit_data;
    logic [WAY_W-1:0]  victim_way;
    logic              touch;
    logic [WAY_W-1:0]  touch_way;

    assign lookup_tag = req_addr[ADDR_W-1:OFFS_W];

    fa_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (st_q.valid),
        .tags_i  (st_q.tag),
        .data_i  (st_q.data),
        .tag_i   (lookup_tag),
        .match_o (match_vec),
        .hit_o   (any_hit),
        .way_o   (hit_way),
        .data_o  (hit_data)
    );

    // hits of either kind and read fills update recency; write misses do not
    assign touch     = req_valid && (any_hit || !req_write);
    assign touch_way = any_hit ? hit_way : victim_way;

    fa_lru_order #(.WAYS(WAYS)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (st_q.valid),
        .touch_i     (touch),
        .touch_way_i (touch_way),
        .victim_o    (victim_way)
    );

    // write-through path to memory
    assign mem_we    = req_valid && req_write;
    assign mem_addr  = lookup_tag;
    assign mem_wdata = req_wdata;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = req_valid && any_hit;
        if (req_valid) begin
            st_d.rsp_way = touch_way;
            if (req_write) begin
                if (any_hit) st_d.data[hit_way] = req_wdata;
                st_d.rsp_data = req_wdata;
            end else if (any_hit) begin
                st_d.rsp_data = hit_data;
            end else begin
                st_d.valid[victim_way] = 1'b1;
                st_d.tag[victim_way]   = lookup_tag;
                st_d.data[victim_way]  = mem_rdata;
                st_d.rsp_data          = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_way   = st_q.rsp_way;
    assign rsp_data  = st_q.rsp_data;

    AST_READ_LEAVES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=>
            (st_q.valid[$past(touch_way)] &&
             st_q.tag[$past(touch_way)] == $past(lookup_tag))); // R4
    AST_WRITE_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !any_hit) |=>
            ($stable(st_q.valid) && $stable(st_q.tag))); // R9
    AST_FILL_ONLY_WHEN_FREE_OR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !any_hit && !(&st_q.valid)) |->
            !st_q.valid[victim_way]); // R5
endmodule

// File: tb/fa_lru_cache_tb_top.sv
`timescale 1ns/1ps
module fa_lru_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [6:0]  req_addr;
    logic [31:0] req_wdata;
    logic        mem_we;
    logic [4:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_way;
    logic [31:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    fa_lru_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data)
    );

    // backing memory
    logic [31:0] mem [32];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // reference model: entries plus a recency queue (front = most recent)
    bit          m_valid [8];
    int          m_tag   [8];
    logic [31:0] m_data  [8];
    int          m_lru[$];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic promote(input int w);
        for (int k = 0; k < m_lru.size(); k++) begin
            if (m_lru[k] == w) begin
                m_lru.delete(k);
                break;
            end
        end
        m_lru.push_front(w);
    endtask

    // one access: drive at a falling edge, check the response at the next one
    task automatic access(input bit wr, input int word, input int offs,
                          input logic [31:0] wd, input string rq, output bit was_hit);
        int hw;
        bit e_hit;
        int e_way;
        logic [31:0] e_data;
        hw = -1;
        for (int k = 0; k < 8; k++) if (m_valid[k] && m_tag[k] == word) hw = k;
        e_hit = (hw >= 0);
        e_way = 0;
        if (wr) begin
            e_data = wd;
            if (e_hit) begin
                m_data[hw] = wd;
                promote(hw);
                e_way = hw;
            end
        end else if (e_hit) begin
            e_data = m_data[hw];
            promote(hw);
            e_way = hw;
        end else begin
            e_way = -1;
            for (int k = 0; k < 8; k++) if (e_way < 0 && !m_valid[k]) e_way = k;
            if (e_way < 0) e_way = m_lru[m_lru.size()-1];
            e_data = mem[word];
            m_valid[e_way] = 1'b1;
            m_tag[e_way]   = word;
            m_data[e_way]  = e_data;
            promote(e_way);
        end
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 7'((word << 2) | offs);
        req_wdata = wd;
        #1;
        if (wr) begin
            check(mem_we == 1'b1, "R9", "mem_we", 32'(mem_we), 32'd1);
            check(mem_addr == 5'(word) && mem_wdata == wd, "R9", "mem_addr/wdata",
                  32'(mem_addr), 32'(word));
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R11", "rsp_valid", 32'(rsp_valid), 32'd1);
        check(rsp_hit == e_hit, rq, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        if (e_hit || !wr)
            check(rsp_way == 3'(e_way), rq, "rsp_way", 32'(rsp_way), 32'(e_way));
        check(rsp_data == e_data, rq, "rsp_data", rsp_data, e_data);
        was_hit = rsp_hit;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R11", "rsp_valid idle", 32'(rsp_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit h;
        int trace [6] = '{0, 8, 0, 6, 8, 16};
        bit exp_tr [6] = '{0, 0, 1, 0, 1, 0};
        logic [15:0] lfsr = 16'hACE1;
        for (int k = 0; k < 32; k++) mem[k] = 32'hA500_0000 + 32'(k) * 32'h111;
        for (int k = 0; k < 8; k++) begin
            m_valid[k] = 1'b0;
            m_tag[k]   = 0;
            m_data[k]  = '0;
        end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        idle(2);

        // R10 and R1: the classic trace from an empty cache
        for (int k = 0; k < 6; k++) begin
            access(1'b0, trace[k], 0, '0, "R10", h);
            check(h == exp_tr[k], "R10", "trace hit pattern", 32'(h), 32'(exp_tr[k]));
        end
        // R2: byte offset ignored
        access(1'b0, 6, 3, '0, "R2", h);
        check(h == 1'b1, "R2", "offset 3 hit", 32'(h), 32'd1);
        access(1'b0, 16, 1, '0, "R2", h);
        idle(1);
        // R5: fill the remaining entries 4..7 in order
        for (int k = 1; k <= 4; k++) access(1'b0, k, 0, '0, "R5", h);
        // R3: hits on all resident words
        access(1'b0, 1, 0, '0, "R3", h);
        access(1'b0, 8, 2, '0, "R3", h);
        // R6/R7: evictions; LRU now word 0 (entry 0)
        access(1'b0, 20, 0, '0, "R6", h);
        access(1'b0, 0, 0, '0, "R6", h);
        check(h == 1'b0, "R6", "evicted word misses", 32'(h), 32'd0);
        // R7: promote in a chosen order then evict
        access(1'b0, 2, 0, '0, "R7", h);
        access(1'b0, 3, 0, '0, "R7", h);
        access(1'b0, 21, 0, '0, "R7", h);
        access(1'b0, 22, 0, '0, "R7", h);
        // R9: write hit, write miss, read back
        access(1'b1, 22, 0, 32'hDEAD_0022, "R9", h);
        access(1'b0, 22, 0, '0, "R9", h);
        access(1'b1, 30, 0, 32'hBEEF_0030, "R9", h);
        check(h == 1'b0, "R9", "write miss", 32'(h), 32'd0);
        access(1'b0, 30, 0, '0, "R9", h);
        check(h == 1'b0 && rsp_data == 32'hBEEF_0030, "R9", "write-through then fill",
              rsp_data, 32'hBEEF_0030);
        // R4/R8: mixed pseudo-random stream
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[2:0] == 3'd0, int'(lfsr[7:4]) + (lfsr[8] ? 16 : 0) * int'(lfsr[9]),
                   int'(lfsr[11:10]), {16'h5A00, lfsr}, "R4", h);
            if (lfsr[14:12] == 3'd0) idle(1);
        end
        idle(2);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule